// File: doc/BRIEF.md
# Prescaled Countdown Timer Channel

This block is one channel of a general-purpose timer. It holds a 32-bit counter that counts down from a programmable start value. An 8-bit prescaler slows the count: the counter steps once every (prescale field + 1) clock cycles, and only while the channel is enabled. When a step would bring the count to zero, the channel raises a one-cycle zero pulse and latches a pending status bit. In periodic mode it then reloads the start value and keeps counting. In one-shot mode it parks at zero and turns itself off. The interrupt line is high while the pending bit and the channel's interrupt enable are both set.

Software reaches the channel through a plain 32-bit register port. A write strobe takes effect on the clock edge. The read data is a combinational function of the address and the current register state. There is no stream traffic, so the port has no valid/ready pair and applies no back-pressure: each write is accepted in the cycle it is presented. The byte offsets are 0x00 for control, 0x04 for the start value, 0x08 for the live count and 0x0C for the pending status. Every other offset, including an offset that is not word-aligned, is unmapped.

Top module: `tmr_channel`

## Requirements
- R1: After reset, control reads 0x00000005, start value 0, live count 0, pending status 0, and irq is 0.
- R2: While the enable bit (control bit 30) is 1, the count drops by one once every (bits 7:0 + 1) cycles. A prescale value of 0 steps the counter every cycle.
- R3: When a step happens while the count is 1 or 0, zero_pulse is 1 for that cycle and the pending bit is set. In periodic mode (bit 27 = 1) the count reloads from the start value and counting continues. In one-shot mode the count becomes 0 and bits 30 and 25 both clear, unless a control write in that same cycle sets the enable bit.
- R4: irq equals the interrupt enable (control bit 29) AND the pending bit.
- R5: Writing control with bit 26 set loads the count from the start value and restarts the prescaler. The same write forces the enable bit to 0 even if bit 30 is 1. Bit 26 always reads as 0.
- R6: Writing offset 0x0C with bit 0 = 1 clears the pending bit, and writing 0 there leaves it unchanged. A zero event in the same cycle wins and leaves the bit set.
- R7: Writes to the live count (0x08) are ignored. Control bits 24:8, 31 and 28 read 0 whatever is written, and writes to bit 25 have no effect.
- R8: The active flag (control bit 25) always equals the enable bit.
- R9: Clearing the enable bit freezes the count. Setting it again resumes counting from the frozen value.
- R10: Writing offset 0x04 stores the start value, loads it into the count and restarts the prescaler.
- R11: A control write that changes bits 7:0 keeps the count value and restarts the prescaler, so the next step comes after the new full division.
- R12: Unmapped offsets read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |
| zero_pulse | output | 1 | One-cycle pulse on each zero event |

## Verification
The bench goes after the write that sets both counter-reset and enable. A design that honoured the enable would start counting from the reloaded value. It also targets a prescale change in the middle of a count: a design that kept the old sub-count or reloaded the counter would step early or jump back to the start value. One-shot expiry is checked to make sure the enable and active bits drop together, since a design that cleared only one of them would leave the control read inconsistent. The pause and resume sequence, writes to the count register, and clearing the pending bit with 0 and then 1 are checked against a reference model on every cycle. A lost freeze, a writable count or a clear that acts on 0 shows up as a count or status mismatch in that cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  localparam int PSC_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_LOAD  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h0C;

  localparam int B_EN   = 30;
  localparam int B_IE   = 29;
  localparam int B_PER  = 27;
  localparam int B_CRST = 26;
  localparam int B_ACT  = 25;

  localparam logic [BUS_W-1:0] CTRL_RST = 32'h0000_0005;

  typedef struct packed {
    logic             en;
    logic             ie;
    logic             per;
    logic             act;
    logic [PSC_W-1:0] psc;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div,
  input  logic         restart,
  output logic         tick
);
  logic [W-1:0] sub_q;

  assign tick = run && (sub_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sub_q <= '0;
    else if (restart) sub_q <= '0;
    else if (run)     sub_q <= tick ? '0 : sub_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         periodic,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         zero
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  assign count = cnt_q;
  assign zero  = tick && !load && (cnt_q <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (zero)  cnt_q <= periodic ? reload : '0;
    else if (tick)  cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              zero,
  input  logic [BUS_W-1:0]  count,
  output logic [BUS_W-1:0]  rdata,
  output ctrl_t             ctrl,
  output logic              load,
  output logic [BUS_W-1:0]  load_val,
  output logic [BUS_W-1:0]  reload,
  output logic              psc_restart,
  output logic              status,
  output logic              irq
);
  ctrl_t            ctrl_q;
  logic [BUS_W-1:0] reload_q;
  logic             stat_q;
  logic             wr_ctrl, wr_load, wr_stat, crst;
  logic             unused_bits;

  assign wr_ctrl = wr && (addr == OFF_CTRL);
  assign wr_load = wr && (addr == OFF_LOAD);
  assign wr_stat = wr && (addr == OFF_STAT);
  assign crst    = wr_ctrl && wdata[B_CRST];

  assign load        = crst || wr_load;
  assign load_val    = wr_load ? wdata : reload_q;
  assign psc_restart = load || (wr_ctrl && (wdata[PSC_W-1:0] != ctrl_q.psc));

  assign unused_bits = ^{wdata[BUS_W-1], wdata[28], wdata[B_ACT-1:PSC_W], wdata[B_ACT]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.en  <= CTRL_RST[B_EN];
      ctrl_q.ie  <= CTRL_RST[B_IE];
      ctrl_q.per <= CTRL_RST[B_PER];
      ctrl_q.act <= CTRL_RST[B_ACT];
      ctrl_q.psc <= CTRL_RST[PSC_W-1:0];
    end else if (wr_ctrl) begin
      ctrl_q.en  <= wdata[B_EN] && !wdata[B_CRST];
      ctrl_q.act <= wdata[B_EN] && !wdata[B_CRST];
      ctrl_q.ie  <= wdata[B_IE];
      ctrl_q.per <= wdata[B_PER];
      ctrl_q.psc <= wdata[PSC_W-1:0];
    end else if (zero && !ctrl_q.per) begin
      ctrl_q.en  <= 1'b0;
      ctrl_q.act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reload_q <= '0;
    else if (wr_load) reload_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   stat_q <= 1'b0;
    else if (zero)                stat_q <= 1'b1;
    else if (wr_stat && wdata[0]) stat_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CTRL: begin
        rdata[B_EN]        = ctrl_q.en;
        rdata[B_IE]        = ctrl_q.ie;
        rdata[B_PER]       = ctrl_q.per;
        rdata[B_ACT]       = ctrl_q.act;
        rdata[PSC_W-1:0]   = ctrl_q.psc;
      end
      OFF_LOAD:  rdata = reload_q;
      OFF_COUNT: rdata = count;
      OFF_STAT:  rdata[0] = stat_q;
      default:   rdata = '0;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign reload = reload_q;
  assign status = stat_q;
  assign irq    = ctrl_q.ie && stat_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              zero_pulse
);
  ctrl_t            ctrl_w;
  logic             load_w, restart_w, tick_w, zero_w, stat_w;
  logic [BUS_W-1:0] load_val_w, reload_w, count_w;
  logic             en_w, act_w, per_w;
  logic [PSC_W-1:0] psc_w;

  tmr_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (bus_wr),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .zero        (zero_w),
    .count       (count_w),
    .rdata       (bus_rdata),
    .ctrl        (ctrl_w),
    .load        (load_w),
    .load_val    (load_val_w),
    .reload      (reload_w),
    .psc_restart (restart_w),
    .status      (stat_w),
    .irq         (irq)
  );

  tmr_prescaler #(.W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_w.en),
    .div     (ctrl_w.psc),
    .restart (restart_w),
    .tick    (tick_w)
  );

  tmr_counter #(.W(BUS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .load     (load_w),
    .load_val (load_val_w),
    .periodic (ctrl_w.per),
    .reload   (reload_w),
    .count    (count_w),
    .zero     (zero_w)
  );

  assign en_w       = ctrl_w.en;
  assign act_w      = ctrl_w.act;
  assign per_w      = ctrl_w.per;
  assign psc_w      = ctrl_w.psc;
  assign zero_pulse = zero_w;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              en,
  input logic              act,
  input logic              per,
  input logic [PSC_W-1:0]  psc,
  input logic              status,
  input logic [BUS_W-1:0]  count,
  input logic              zero
);
  AST_ZERO_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> status); // R3

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !per && !(bus_wr && bus_addr == OFF_CTRL)) |=> (!en && count == '0)); // R3

  AST_SINGLE_ZERO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && psc != '0) |=> !zero); // R2

  AST_RESET_BEATS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CTRL && bus_wdata[B_CRST]) |=> !en); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_STAT && bus_wdata[0] && !zero) |=> !status); // R6

  AST_COUNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_COUNT && !en) |=> (count == $past(count))); // R7

  AST_ACT_MIRRORS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    act == en); // R8

  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !bus_wr) |=> (count == $past(count))); // R9
endmodule

bind tmr_channel tmr_channel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .en        (en_w),
  .act       (act_w),
  .per       (per_w),
  .psc       (psc_w),
  .status    (stat_w),
  .count     (count_w),
  .zero      (zero_w)
);

// File: tb/tmr_channel_bench.sv
`timescale 1ns/1ps
module tmr_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, zero_pulse;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic        m_en, m_ie, m_per, m_stat;
  logic [7:0]  m_psc;
  logic [31:0] m_reload, m_count;
  int          m_sub;

  always #4 clk = ~clk;

  tmr_channel u_tmr_channel (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .zero_pulse(zero_pulse)
  );

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 8'h00) begin
      r[30] = m_en; r[29] = m_ie; r[27] = m_per; r[25] = m_en; r[7:0] = m_psc;
    end else if (a == 8'h04) r = m_reload;
    else if (a == 8'h08) r = m_count;
    else if (a == 8'h0C) r[0] = m_stat;
    return r;
  endfunction

  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d, input string tag);
    logic tk, wc, wl, ws, ld, zr;
    logic n_en, n_ie, n_per, n_stat;
    logic [7:0] n_psc;
    logic [31:0] n_reload, n_count;
    int n_sub;
    bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    wc = w && (a == 8'h00);
    wl = w && (a == 8'h04);
    ws = w && (a == 8'h0C);
    ld = (wc && d[26]) || wl;
    tk = m_en && (m_sub == int'(m_psc));
    zr = tk && !ld && (m_count <= 32'd1);
    check(tag, "rdata", bus_rdata, mread(a));
    check(tag, "irq", {31'b0, irq}, {31'b0, m_ie && m_stat});
    check(tag, "zero_pulse", {31'b0, zero_pulse}, {31'b0, zr});
    if (ld || (wc && d[7:0] != m_psc)) n_sub = 0;
    else if (m_en) n_sub = tk ? 0 : m_sub + 1;
    else n_sub = m_sub;
    if (wl) n_count = d;
    else if (wc && d[26]) n_count = m_reload;
    else if (zr) n_count = m_per ? m_reload : 32'd0;
    else if (tk) n_count = m_count - 32'd1;
    else n_count = m_count;
    if (wc) n_en = d[30] && !d[26];
    else if (zr && !m_per) n_en = 1'b0;
    else n_en = m_en;
    n_ie  = wc ? d[29] : m_ie;
    n_per = wc ? d[27] : m_per;
    n_psc = wc ? d[7:0] : m_psc;
    n_reload = wl ? d : m_reload;
    if (zr) n_stat = 1'b1;
    else if (ws && d[0]) n_stat = 1'b0;
    else n_stat = m_stat;
    @(posedge clk);
    m_en = n_en; m_ie = n_ie; m_per = n_per; m_psc = n_psc;
    m_reload = n_reload; m_count = n_count; m_sub = n_sub; m_stat = n_stat;
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h08, 32'h0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_wr = 1'b0; bus_addr = a; #1;
    check(tag, "literal", bus_rdata, exp);
    cyc(1'b0, a, 32'h0, tag);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    bus_wr = 1'b0; #1;
    check(tag, "irq literal", {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_ie = 0; m_per = 0; m_stat = 0; m_psc = 8'h05;
    m_reload = '0; m_count = '0; m_sub = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk_irq(1'b0, "R1");
    rd(8'h00, 32'h0000_0005, "R1");
    rd(8'h04, 32'h0, "R1");
    rd(8'h08, 32'h0, "R1");
    rd(8'h0C, 32'h0, "R1");
    // R12 unmapped offsets
    cyc(1'b1, 8'h10, 32'hFFFF_FFFF, "R12");
    rd(8'h10, 32'h0, "R12");
    rd(8'h02, 32'h0, "R12");
    rd(8'h00, 32'h0000_0005, "R12");
    // R7 reserved and active bits dropped, count read-only
    cyc(1'b1, 8'h00, 32'h93FF_FF00, "R7");
    rd(8'h00, 32'h0, "R7");
    cyc(1'b1, 8'h08, 32'h0000_1234, "R7");
    rd(8'h08, 32'h0, "R7");
    // R10 start value loads the count
    cyc(1'b1, 8'h04, 32'd5, "R10");
    rd(8'h08, 32'd5, "R10");
    rd(8'h04, 32'd5, "R10");
    // R2 / R3 periodic with divide by one
    cyc(1'b1, 8'h00, 32'h6800_0000, "R2");
    rd(8'h08, 32'd5, "R2");
    rd(8'h08, 32'd4, "R2");
    run(12, "R3");
    chk_irq(1'b1, "R4");
    // stop, then R6 clear semantics
    cyc(1'b1, 8'h00, 32'h2800_0000, "R9");
    rd(8'h00, 32'h2800_0000, "R8");
    cyc(1'b1, 8'h0C, 32'h0, "R6");
    rd(8'h0C, 32'h1, "R6");
    cyc(1'b1, 8'h0C, 32'h1, "R6");
    rd(8'h0C, 32'h0, "R6");
    chk_irq(1'b0, "R4");
    // one-shot with divide by four
    cyc(1'b1, 8'h04, 32'd3, "R10");
    cyc(1'b1, 8'h00, 32'h4000_0003, "R3");
    rd(8'h00, 32'h4200_0003, "R8");
    run(20, "R3");
    rd(8'h00, 32'h0000_0003, "R3");
    rd(8'h08, 32'h0, "R3");
    rd(8'h0C, 32'h1, "R3");
    chk_irq(1'b0, "R4");
    // R5 counter reset beats enable
    cyc(1'b1, 8'h00, 32'h4400_0003, "R5");
    rd(8'h00, 32'h0000_0003, "R5");
    rd(8'h08, 32'd3, "R5");
    // R9 pause and resume
    cyc(1'b1, 8'h04, 32'd10, "R9");
    cyc(1'b1, 8'h00, 32'h4000_0001, "R9");
    run(6, "R9");
    cyc(1'b1, 8'h00, 32'h0000_0001, "R9");
    run(5, "R9");
    cyc(1'b1, 8'h00, 32'h4000_0001, "R9");
    run(10, "R9");
    // R11 prescale change keeps the count
    cyc(1'b1, 8'h00, 32'h0000_0000, "R11");
    cyc(1'b1, 8'h04, 32'd20, "R11");
    cyc(1'b1, 8'h00, 32'h4000_0000, "R11");
    rd(8'h08, 32'd20, "R11");
    rd(8'h08, 32'd19, "R11");
    rd(8'h08, 32'd18, "R11");
    cyc(1'b1, 8'h00, 32'h4000_0004, "R11");
    rd(8'h08, 32'd16, "R11");
    rd(8'h08, 32'd16, "R11");
    run(12, "R11");
    // periodic with divide by two, clears raced against zero events
    cyc(1'b1, 8'h04, 32'd2, "R6");
    cyc(1'b1, 8'h00, 32'h6800_0001, "R6");
    for (int i = 0; i < 12; i++) cyc(1'b1, 8'h0C, 32'h1, "R6");
    run(6, "R4");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule